// File: doc/BRIEF.md
# Table jump dispatch unit

This unit executes the two 16-bit table-jump instructions of a compressed instruction set. Both share one major-opcode slot and are told apart only by the value of their index. The unit checks the encoding and forms the address of a word-sized jump-table entry from a table base value and the index. It reads that entry through a request/valid memory handshake and then sends the core a one-cycle PC redirect to the fetched target. The linking variant also writes the return address into register x1 in the same cycle as the redirect.

The core presents an instruction with `instr_valid` while `busy` is low. From acceptance until the table word returns, the unit holds `busy` and ignores any new instruction. A halfword that is not a table jump is rejected with a one-cycle `illegal` pulse and starts no memory read.

Top module: `tbl_jump_unit`

## Requirements
- R1: After reset, `busy`, `mem_req`, `redir_valid`, `link_we` and `illegal` are all 0.
- R2: An instruction is a table jump only when bits [15:13] = 101, bits [1:0] = 10 and bits [12:10] = 000. Any other halfword accepted with `instr_valid` makes `illegal` 1 for exactly the next cycle and starts no memory read.
- R3: A table jump whose 8-bit field at bits [9:2] is below 32 is the plain form, so bits [12:7] are zero and the index sits in bits [6:2]. Its entry address is `tbl_base + 4*index`.
- R4: A table jump whose field at bits [9:2] is 32 or more is the linking form. Its entry address is `tbl_base + 4*index`, using the full 8-bit index.
- R5: From the cycle after acceptance, `busy` and `mem_req` stay 1 with `mem_addr` unchanged, through the cycle in which `mem_rvalid` is sampled high.
- R6: The cycle after `mem_rvalid` is sampled high during a read, `redir_valid` is 1 for exactly one cycle and `busy` and `mem_req` are 0. `redir_pc` equals `mem_rdata` with bit 0 cleared.
- R7: For the linking form, `link_we` is 1 together with `redir_valid`, with `link_rd` = 1 and `link_data` equal to the instruction PC plus 2. For the plain form, `link_we` stays 0.
- R8: An `instr_valid` that arrives while `busy` is 1 is ignored. It raises no `illegal`, does not change `mem_addr`, and does not alter the pending redirect or link.
- R9: A `mem_rvalid` that arrives while no read is pending is ignored and produces no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| instr_valid | input | 1 | Instruction presented |
| instr | input | 16 | Compressed instruction |
| instr_pc | input | XLEN | PC of the instruction |
| tbl_base | input | XLEN | Jump-table base address |
| mem_req | output | 1 | Table read request, held until data returns |
| mem_addr | output | XLEN | Table entry address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | XLEN | Read data (entry) |
| busy | output | 1 | Read in flight, new instructions ignored |
| redir_valid | output | 1 | One-cycle PC redirect |
| redir_pc | output | XLEN | Redirect target |
| link_we | output | 1 | Return-address write enable |
| link_rd | output | 5 | Destination register of the link write |
| link_data | output | XLEN | Return address |
| illegal | output | 1 | One-cycle illegal-instruction pulse |

## Verification
The hardest situation to reach is a second instruction, or a stray read-valid, arriving in the middle of a pending table read, because it needs a read latency of more than zero cycles. The stimulus draws a random latency of zero to three cycles for each jump. During the wait it sometimes presents another legal or illegal instruction, and it checks afterwards that the address, target and link come only from the first instruction. The boundary indices 31 and 32, the largest index 255, and near-miss encodings with only bits [12:10] non-zero are also driven as directed cases.

// File: rtl/tbl_jump_unit.sv
module tbl_jump_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [15:0]     instr,
  input  logic [XLEN-1:0] instr_pc,
  input  logic [XLEN-1:0] tbl_base,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  input  logic            mem_rvalid,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            busy,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output logic            link_we,
  output logic [4:0]      link_rd,
  output logic [XLEN-1:0] link_data,
  output logic            illegal
);
  localparam int ENT_SHIFT = $clog2(XLEN / 8);

  logic            busy_q, link_q, redir_q, lwe_q, ill_q;
  logic [XLEN-1:0] addr_q, ret_q, tgt_q;

  wire       is_tj   = (instr[15:13] == 3'b101) && (instr[1:0] == 2'b10) && (instr[12:10] == 3'b000);
  wire [7:0] idx     = instr[9:2];
  wire       is_link = (idx[7:5] != 3'b000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      link_q  <= 1'b0;
      redir_q <= 1'b0;
      lwe_q   <= 1'b0;
      ill_q   <= 1'b0;
      addr_q  <= '0;
      ret_q   <= '0;
      tgt_q   <= '0;
    end else begin
      redir_q <= 1'b0;
      lwe_q   <= 1'b0;
      ill_q   <= 1'b0;
      if (busy_q) begin
        if (mem_rvalid) begin
          busy_q  <= 1'b0;
          redir_q <= 1'b1;
          lwe_q   <= link_q;
          tgt_q   <= {mem_rdata[XLEN-1:1], 1'b0};
        end
      end else if (instr_valid) begin
        if (is_tj) begin
          busy_q <= 1'b1;
          link_q <= is_link;
          addr_q <= tbl_base + (XLEN'(idx) << ENT_SHIFT);
          ret_q  <= instr_pc + XLEN'(2);
        end else begin
          ill_q <= 1'b1;
        end
      end
    end
  end

  assign busy        = busy_q;
  assign mem_req     = busy_q;
  assign mem_addr    = addr_q;
  assign redir_valid = redir_q;
  assign redir_pc    = tgt_q;
  assign link_we     = lwe_q;
  assign link_rd     = lwe_q ? 5'd1 : 5'd0;
  assign link_data   = ret_q;
  assign illegal     = ill_q;
endmodule

// File: rtl/tbl_jump_unit_chk.sv
module tbl_jump_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic [XLEN-1:0] mem_addr,
  input logic            mem_rvalid,
  input logic            busy,
  input logic            redir_valid,
  input logic [XLEN-1:0] redir_pc,
  input logic            link_we,
  input logic [4:0]      link_rd,
  input logic            illegal
);
  AST_ILLEGAL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_req);  // R2
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> $stable(mem_addr));  // R5
  AST_REDIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !redir_valid);  // R6
  AST_REDIR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> $past(mem_req && mem_rvalid));  // R6
  AST_REDIR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (!busy && !redir_pc[0]));  // R6
  AST_LINK_WITH_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (redir_valid && link_rd == 5'd1));  // R7
  AST_NO_STRAY_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mem_req)) |-> !redir_valid);  // R9
endmodule

bind tbl_jump_unit tbl_jump_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .busy(busy), .redir_valid(redir_valid),
  .redir_pc(redir_pc), .link_we(link_we), .link_rd(link_rd), .illegal(illegal)
);

// File: tb/tbl_jump_unit_test.sv
`timescale 1ns/1ps
module tbl_jump_unit_test;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            instr_valid = 1'b0;
  logic [15:0]     instr = '0;
  logic [XLEN-1:0] instr_pc = '0, tbl_base = '0, mem_rdata = '0;
  logic            mem_rvalid = 1'b0;
  logic            mem_req, busy, redir_valid, link_we, illegal;
  logic [XLEN-1:0] mem_addr, redir_pc, link_data;
  logic [4:0]      link_rd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tbl_jump_unit #(.XLEN(XLEN)) uut (.*);

  function automatic logic [15:0] enc_plain(input logic [4:0] i);
    return {3'b101, 6'b000000, i, 2'b10};
  endfunction
  function automatic logic [15:0] enc_link(input logic [7:0] i);
    return {3'b101, 3'b000, i, 2'b10};
  endfunction
  function automatic bit is_tj(input logic [15:0] x);
    return x[15:13] == 3'b101 && x[1:0] == 2'b10 && x[12:10] == 3'b000;
  endfunction
  function automatic logic [XLEN-1:0] exp_addr(input logic [XLEN-1:0] b, input logic [7:0] i);
    return b + {22'd0, i, 2'b00};
  endfunction

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic run_jump(input logic [15:0] ins, input logic [XLEN-1:0] pc,
                          input logic [XLEN-1:0] base, input logic [XLEN-1:0] data,
                          input int lat, input bit poke);
    logic [7:0] i = ins[9:2];
    bit lnk = (i >= 8'd32);
    logic [XLEN-1:0] ea = exp_addr(base, i);
    instr = ins; instr_pc = pc; tbl_base = base; instr_valid = 1'b1;
    tick;
    instr_valid = 1'b0;
    chk(lnk ? "R4 addr" : "R3 addr", mem_addr, ea);
    chk("R5 busy", {31'd0, busy}, 32'd1);
    chk("R5 req", {31'd0, mem_req}, 32'd1);
    for (int k = 0; k < lat; k++) begin
      if (poke) begin
        instr = ($urandom % 2) ? enc_link(8'd200) : 16'hFFFF;
        instr_pc = $urandom; tbl_base = $urandom; instr_valid = 1'b1;
      end
      tick;
      instr_valid = 1'b0;
      chk("R5 held", {31'd0, mem_req}, 32'd1);
      chk(poke ? "R8 addr kept" : "R5 addr kept", mem_addr, ea);
      if (poke) chk("R8 no illegal", {31'd0, illegal}, 32'd0);
    end
    mem_rdata = data; mem_rvalid = 1'b1;
    tick;
    mem_rvalid = 1'b0;
    chk("R6 redir", {31'd0, redir_valid}, 32'd1);
    chk("R6 target", redir_pc, {data[XLEN-1:1], 1'b0});
    chk("R6 busy low", {31'd0, busy}, 32'd0);
    chk("R6 req low", {31'd0, mem_req}, 32'd0);
    chk("R7 link_we", {31'd0, link_we}, {31'd0, lnk});
    if (lnk) begin
      chk("R7 link_rd", {27'd0, link_rd}, 32'd1);
      chk("R7 link_data", link_data, pc + 32'd2);
    end
    tick;
    chk("R6 one cycle", {31'd0, redir_valid}, 32'd0);
    chk("R7 link one cycle", {31'd0, link_we}, 32'd0);
  endtask

  task automatic run_illegal(input logic [15:0] ins);
    instr = ins; instr_valid = 1'b1;
    tick;
    instr_valid = 1'b0;
    chk("R2 illegal", {31'd0, illegal}, 32'd1);
    chk("R2 no req", {31'd0, mem_req}, 32'd0);
    tick;
    chk("R2 one cycle", {31'd0, illegal}, 32'd0);
  endtask

  task automatic stray_rvalid;
    mem_rvalid = 1'b1; mem_rdata = $urandom;
    tick;
    mem_rvalid = 1'b0;
    chk("R9 no redir", {31'd0, redir_valid}, 32'd0);
    chk("R9 no busy", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tick; tick;
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 req", {31'd0, mem_req}, 32'd0);
    chk("R1 redir", {31'd0, redir_valid}, 32'd0);
    chk("R1 link", {31'd0, link_we}, 32'd0);
    chk("R1 illegal", {31'd0, illegal}, 32'd0);
    rst_n = 1'b1;
    tick;
    run_jump(enc_plain(5'd0), 32'h0000_1000, 32'h0002_0000, 32'h0000_4001, 0, 1'b0);
    run_jump(enc_plain(5'd31), 32'h0000_1002, 32'h0002_0000, 32'h0000_5555, 2, 1'b0);
    run_jump(enc_link(8'd32), 32'h0000_2000, 32'h0003_0004, 32'h8000_0003, 1, 1'b0);
    run_jump(enc_link(8'd255), 32'hFFFF_FFFE, 32'hFFFF_FF00, 32'h1234_5679, 3, 1'b1);
    run_illegal(16'hA002 | 16'h0400);
    run_illegal(16'hA002 | 16'h1000);
    run_illegal(16'h0000);
    stray_rvalid();
    for (int n = 0; n < 300; n++) begin
      int kind = $urandom % 4;
      if (kind == 0) run_jump(enc_plain(5'($urandom)), $urandom, $urandom, $urandom, $urandom % 4, 1'($urandom));
      else if (kind == 1) run_jump(enc_link(8'd32 + 8'($urandom % 224)), $urandom, $urandom, $urandom, $urandom % 4, 1'($urandom));
      else if (kind == 2) begin
        logic [15:0] x;
        if ($urandom % 2) x = {3'b101, 3'(1 + $urandom % 7), 8'($urandom), 2'b10};
        else begin
          x = 16'($urandom);
          while (is_tj(x)) x = 16'($urandom);
        end
        run_illegal(x);
      end else stray_rvalid();
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule